// File: doc/BRIEF.md
# Supply Health Monitor and Reset Generator

This block watches three supply channels through their under-voltage and over-voltage comparator flags. Each raw flag passes through its own digital persistence filter, counted in timebase ticks, so that a short excursion is dropped and only a condition that lasts is taken as a confirmed fault. Confirmed faults on enabled channels are shown as live bits, are latched into sticky status bits, raise a shutdown request toward the sequencer, and decide the level of one shared output pin.

The pin works in one of two modes. In health mode it simply reports whether every enabled channel is inside its window. In reset mode it acts as an active-low reset: it is held low while any enabled channel is faulted or while a host reset input is high. It is released only after a programmable delay has run with good conditions throughout. The pad itself is open-drain, so the block outputs a drive-low enable rather than a level.

Top module: `shm_top`

## Requirements
- R1: Each of the six raw flags (UV and OV per channel) has a filter that counts `tick_i` pulses while the raw flag is high, restarts from zero in the first clock edge at which the raw flag is low, and shows a live fault once the count reaches the selected length; a raw pulse shorter than the length never shows as live.
- R2: `filt_sel_i` selects the filter length for all flags: 0 gives 1 tick, 1 gives 4, 2 gives 16, 3 gives 64.
- R3: A channel with its `ch_en_i` bit low shows no live bit, sets no sticky bit, raises no fault request and does not pull the pin low; its filters keep counting, so enabling it shows an already confirmed fault at once.
- R4: `fault_o` is high exactly while any live bit is high.
- R5: Each sticky bit is set by its live bit and holds until a one is written on its clear strobe; when the live bit and the clear strobe meet in the same cycle the bit stays set. Bit index i of every per-channel vector is channel i.
- R6: In health mode (`rst_mode_i` = 0), `pin_low_o` is 1 one clock after any live bit is 1 and 0 one clock after none is; `host_rst_i` has no effect.
- R7: In reset mode (`rst_mode_i` = 1), `pin_low_o` goes to 0 at the (D+1)-th consecutive clock edge at which all enabled channels are valid and `host_rst_i` is low, where D is `rel_dly_i`.
- R8: In reset mode, `host_rst_i` high makes `pin_low_o` 1 at the next clock edge and keeps it there while high.
- R9: In reset mode, a host reset or a loss of validity during the countdown restarts it from zero.
- R10: `pin_low_o` is 1 during reset and stays 1 until one full filter length of ticks has elapsed after reset, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Filter timebase strobe |
| filt_sel_i | input | 2 | Filter length code |
| ch_en_i | input | NCH | Channel enables |
| uv_raw_i | input | NCH | Raw under-voltage comparator flags |
| ov_raw_i | input | NCH | Raw over-voltage comparator flags |
| uv_clr_i | input | NCH | Write-one-to-clear strobes for UV sticky bits |
| ov_clr_i | input | NCH | Write-one-to-clear strobes for OV sticky bits |
| rst_mode_i | input | 1 | 0 health level, 1 delayed reset |
| host_rst_i | input | 1 | Host reset request, active high |
| rel_dly_i | input | DLY_W | Release delay in clock cycles |
| uv_live_o | output | NCH | Filtered, masked UV state |
| ov_live_o | output | NCH | Filtered, masked OV state |
| uv_sticky_o | output | NCH | Latched UV status |
| ov_sticky_o | output | NCH | Latched OV status |
| fault_o | output | 1 | Shutdown request to the sequencer |
| pin_low_o | output | 1 | Drive-low enable for the open-drain pin |

## Verification
Two functions can meet in one cycle: a fault becoming confirmed, which sets a sticky bit, and a software clear of that same bit. The bench raises a raw flag with a one-tick filter and drives the clear strobe in the very cycle the live bit first shows, then expects the sticky bit to read set; it then drops the raw flag and expects the same strobe alone to clear the bit. A second collision, a fault arriving mid-countdown in reset mode, is judged by counting the exact edge of release after the fault goes away.

// File: rtl/shm_pkg.sv
package shm_pkg;
    localparam int FCNT_W = 7;
    typedef logic [FCNT_W-1:0] fcnt_t;

    function automatic fcnt_t filt_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return fcnt_t'(1);
            2'd1:    return fcnt_t'(4);
            2'd2:    return fcnt_t'(16);
            default: return fcnt_t'(64);
        endcase
    endfunction
endpackage

// File: rtl/shm_glitch_filt.sv
module shm_glitch_filt
    import shm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  raw_i,
    input  fcnt_t len_i,
    output logic  flag_o
);
    typedef struct packed {
        fcnt_t cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!raw_i)
            st_d.cnt = '0;
        else if (tick_i && st_q.cnt < len_i)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = (st_q.cnt >= len_i);

    // R1: a low raw flag clears the filter by the next edge
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_i |=> !flag_o);
    // R1: a confirmed flag implies the raw flag was high at the last edge
    a_r1_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |-> $past(raw_i));
    // R2: the counter never passes the longest length
    a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= fcnt_t'(64));
endmodule

// File: rtl/shm_sticky.sv
module shm_sticky #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] live_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sticky_o
);
    typedef struct packed {
        logic [N-1:0] bits;
    } stk_st_t;

    stk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.bits = (st_q.bits & ~clr_i) | live_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky_o = st_q.bits;

    // R5: a live fault is always captured, even against a clear
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(live_i) & ~sticky_o) == '0));
    // R5: an uncleared bit never drops
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(sticky_o) & ~$past(clr_i) & ~sticky_o) == '0));
endmodule

// File: rtl/shm_rel_timer.sv
module shm_rel_timer
    import shm_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  fcnt_t            len_i,
    input  logic             valid_i,
    input  logic             mode_i,
    input  logic             host_rst_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             pin_low_o
);
    typedef struct packed {
        fcnt_t            eval;
        logic             init;
        logic [DLY_W-1:0] cnt;
        logic             pin_low;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    good;

    always_comb begin
        st_d = st_q;
        if (tick_i && st_q.eval < len_i)
            st_d.eval = st_q.eval + 1'b1;
        if (st_q.eval >= len_i)
            st_d.init = 1'b1;
        good = st_q.init && valid_i;
        if (!mode_i) begin
            st_d.cnt     = '0;
            st_d.pin_low = !good;
        end else if (!good || host_rst_i) begin
            st_d.cnt     = '0;
            st_d.pin_low = 1'b1;
        end else if (!st_q.pin_low || st_q.cnt >= dly_i) begin
            st_d.pin_low = 1'b0;
        end else begin
            st_d.cnt     = st_q.cnt + 1'b1;
            st_d.pin_low = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.pin_low <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_low_o = st_q.pin_low;

    // R6: health mode follows validity one edge later
    a_r6_health: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !valid_i) |=> pin_low_o);
    // R8: host reset pulls the pin at the next edge
    a_r8_host: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && host_rst_i) |=> pin_low_o);
    // R7: a release in reset mode only follows good conditions
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pin_low_o) && $past(mode_i)) |-> ($past(valid_i) && !$past(host_rst_i)));
    // R10: the pin stays low until the first evaluation is complete
    a_r10_init: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.init |=> pin_low_o);
endmodule

// File: rtl/shm_top.sv
module shm_top
    import shm_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [1:0]       filt_sel_i,
    input  logic [NCH-1:0]   ch_en_i,
    input  logic [NCH-1:0]   uv_raw_i,
    input  logic [NCH-1:0]   ov_raw_i,
    input  logic [NCH-1:0]   uv_clr_i,
    input  logic [NCH-1:0]   ov_clr_i,
    input  logic             rst_mode_i,
    input  logic             host_rst_i,
    input  logic [DLY_W-1:0] rel_dly_i,
    output logic [NCH-1:0]   uv_live_o,
    output logic [NCH-1:0]   ov_live_o,
    output logic [NCH-1:0]   uv_sticky_o,
    output logic [NCH-1:0]   ov_sticky_o,
    output logic             fault_o,
    output logic             pin_low_o
);
    localparam int NF = 2 * NCH;

    fcnt_t         len;
    logic [NF-1:0] raw_all;
    logic [NF-1:0] en_all;
    logic [NF-1:0] flag_all;
    logic [NF-1:0] live_all;
    logic [NF-1:0] clr_all;
    logic [NF-1:0] sticky_all;
    logic          valid;

    assign len     = filt_len(filt_sel_i);
    assign raw_all = {ov_raw_i, uv_raw_i};
    assign en_all  = {ch_en_i, ch_en_i};
    assign clr_all = {ov_clr_i, uv_clr_i};

    for (genvar f = 0; f < NF; f++) begin : g_filt
        shm_glitch_filt u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .raw_i  (raw_all[f]),
            .len_i  (len),
            .flag_o (flag_all[f])
        );
    end

    assign live_all = flag_all & en_all;
    assign valid    = ~|live_all;

    shm_sticky #(.N(NF)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .live_i   (live_all),
        .clr_i    (clr_all),
        .sticky_o (sticky_all)
    );

    shm_rel_timer #(.DLY_W(DLY_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .len_i      (len),
        .valid_i    (valid),
        .mode_i     (rst_mode_i),
        .host_rst_i (host_rst_i),
        .dly_i      (rel_dly_i),
        .pin_low_o  (pin_low_o)
    );

    assign uv_live_o   = live_all[NCH-1:0];
    assign ov_live_o   = live_all[NF-1:NCH];
    assign uv_sticky_o = sticky_all[NCH-1:0];
    assign ov_sticky_o = sticky_all[NF-1:NCH];
    assign fault_o     = !valid;

    // R3: a disabled channel never latches new status
    a_r3_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((uv_sticky_o & ~$past(uv_sticky_o) & ~$past(ch_en_i)) == '0));
endmodule

// File: tb/shm_top_test.sv
module shm_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] filt_sel_i = 2'd3;
    logic [2:0] ch_en_i = 3'b111;
    logic [2:0] uv_raw_i = '0, ov_raw_i = '0, uv_clr_i = '0, ov_clr_i = '0;
    logic       rst_mode_i = 1'b0, host_rst_i = 1'b0;
    logic [7:0] rel_dly_i = 8'd0;
    logic [2:0] uv_live_o, ov_live_o, uv_sticky_o, ov_sticky_o;
    logic       fault_o, pin_low_o;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    shm_top uut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        cyc(2);
        chk("R10 pin low in reset", pin_low_o, 1);
        chk("R5 sticky clear in reset", {uv_sticky_o, ov_sticky_o}, 0);
        rst_n = 1'b1;
        cyc(20);
        chk("R10 held without ticks", pin_low_o, 1);
        filt_sel_i = 2'd0;
        tick_i = 1'b1;
        cyc(1);
        chk("R10 held right after first tick", pin_low_o, 1);
        cyc(3);
        chk("R10 released after evaluation", pin_low_o, 0);
    endtask

    task automatic t_filter;
        filt_sel_i = 2'd1;
        uv_raw_i[0] = 1'b1;
        cyc(3);
        chk("R1 not live before 4 ticks", uv_live_o, 0);
        cyc(1);
        chk("R2 live at 4 ticks", uv_live_o, 3'b001);
        chk("R4 fault with live", fault_o, 1);
        cyc(1);
        chk("R6 pin low after fault", pin_low_o, 1);
        uv_raw_i[0] = 1'b0;
        cyc(1);
        chk("R1 live drops on raw clear", uv_live_o, 0);
        chk("R4 fault drops", fault_o, 0);
        cyc(1);
        chk("R6 pin releases", pin_low_o, 0);
        uv_clr_i = 3'b111; cyc(1); uv_clr_i = '0;
        ov_raw_i[2] = 1'b1;
        cyc(3);
        ov_raw_i[2] = 1'b0;
        cyc(2);
        chk("R1 glitch ignored live", ov_live_o, 0);
        chk("R1 glitch ignored sticky", ov_sticky_o, 0);
        chk("R1 glitch ignored pin", pin_low_o, 0);
    endtask

    task automatic t_lengths;
        filt_sel_i = 2'd2;
        ov_raw_i[1] = 1'b1;
        cyc(15);
        chk("R2 sel2 not live at 15", ov_live_o, 0);
        cyc(1);
        chk("R2 sel2 live at 16", ov_live_o, 3'b010);
        ov_raw_i[1] = 1'b0; cyc(1);
        filt_sel_i = 2'd3;
        ov_raw_i[1] = 1'b1;
        cyc(63);
        chk("R2 sel3 not live at 63", ov_live_o, 0);
        cyc(1);
        chk("R2 sel3 live at 64", ov_live_o, 3'b010);
        ov_raw_i[1] = 1'b0; cyc(1);
        filt_sel_i = 2'd0;
        tick_i = 1'b0;
        uv_raw_i[1] = 1'b1;
        cyc(5);
        chk("R1 no count without tick", uv_live_o, 0);
        tick_i = 1'b1;
        cyc(1);
        chk("R2 sel0 live after one tick", uv_live_o, 3'b010);
        uv_raw_i[1] = 1'b0;
        cyc(2);
        uv_clr_i = 3'b111; ov_clr_i = 3'b111; cyc(1);
        uv_clr_i = '0; ov_clr_i = '0;
    endtask

    task automatic t_mask;
        ch_en_i = 3'b101;
        ov_raw_i[1] = 1'b1;
        cyc(5);
        chk("R3 masked live", ov_live_o, 0);
        chk("R3 masked sticky", ov_sticky_o, 0);
        chk("R3 masked fault", fault_o, 0);
        chk("R3 masked pin", pin_low_o, 0);
        ch_en_i = 3'b111;
        #1;
        chk("R3 enable shows confirmed fault", ov_live_o, 3'b010);
        ov_raw_i[1] = 1'b0;
        cyc(3);
        ov_clr_i = 3'b111; cyc(1); ov_clr_i = '0;
        chk("R5 clear after mask test", ov_sticky_o, 0);
    endtask

    task automatic t_sticky;
        uv_raw_i[2] = 1'b1;
        cyc(1);
        chk("R1 live after one tick", uv_live_o, 3'b100);
        uv_clr_i[2] = 1'b1;
        cyc(1);
        uv_clr_i[2] = 1'b0;
        chk("R5 set wins over clear", uv_sticky_o, 3'b100);
        uv_raw_i[2] = 1'b0;
        cyc(4);
        chk("R5 sticky holds", uv_sticky_o, 3'b100);
        uv_clr_i[2] = 1'b1;
        cyc(1);
        uv_clr_i[2] = 1'b0;
        chk("R5 clear strobe", uv_sticky_o, 0);
    endtask

    task automatic t_health_host;
        host_rst_i = 1'b1;
        cyc(3);
        chk("R6 host ignored in health mode", pin_low_o, 0);
        host_rst_i = 1'b0;
    endtask

    task automatic t_delay;
        rst_mode_i = 1'b1;
        rel_dly_i = 8'd5;
        host_rst_i = 1'b1;
        cyc(1);
        chk("R8 host asserts at next edge", pin_low_o, 1);
        cyc(2);
        host_rst_i = 1'b0;
        cyc(5);
        chk("R7 low before delay", pin_low_o, 1);
        cyc(1);
        chk("R7 release after delay", pin_low_o, 0);
        rel_dly_i = 8'd0;
        host_rst_i = 1'b1; cyc(2); host_rst_i = 1'b0;
        cyc(1);
        chk("R7 zero delay release", pin_low_o, 0);
        rel_dly_i = 8'd5;
    endtask

    task automatic t_restart;
        host_rst_i = 1'b1; cyc(1); host_rst_i = 1'b0;
        cyc(3);
        host_rst_i = 1'b1; cyc(1); host_rst_i = 1'b0;
        cyc(5);
        chk("R9 host restart low", pin_low_o, 1);
        cyc(1);
        chk("R9 host restart release", pin_low_o, 0);
        host_rst_i = 1'b1; cyc(1); host_rst_i = 1'b0;
        cyc(3);
        uv_raw_i[0] = 1'b1;
        cyc(1);
        uv_raw_i[0] = 1'b0;
        cyc(6);
        chk("R9 fault restart low", pin_low_o, 1);
        cyc(1);
        chk("R9 fault restart release", pin_low_o, 0);
    endtask

    initial begin
        t_reset();
        t_filter();
        t_lengths();
        t_mask();
        t_sticky();
        t_health_host();
        t_delay();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule